// File: doc/BRIEF.md
# Processor-Port Memory Bank Decoder

This block keeps a three-bit banking control register that the CPU reads and writes at address `$0001`. It turns every CPU address into a one-hot target select. The possible targets are RAM, the BASIC ROM, the KERNAL ROM, the character ROM and the I/O space. Three switched windows depend on the control bits: `$A000-$BFFF`, `$D000-$DFFF` and `$E000-$FFFF`. All other addresses go to RAM, except the two port addresses at the bottom of the map.

The low bit (`lo_en`) and the middle bit (`hi_en`) together decide which ROMs are visible in the upper windows. The top bit (`io_sel`) picks between character ROM and I/O for the `$D000` window, but only while `lo_en` or `hi_en` is set. Colour RAM is treated as part of I/O, so the CPU sees it exactly when the I/O target is selected.

A write never lands in a ROM. A write into a window that is mapped to ROM selects the RAM underneath, and a read from the same address selects the ROM. Control-register updates take effect on the clock edge after the write.

Top module: `pport_bank_map`

## Requirements
- R1: During and right after reset the control register holds 3'b111 (`lo_en`=bit 0, `hi_en`=bit 1, `io_sel`=bit 2), so the map shows BASIC, I/O and KERNAL.
- R2: A write (`cpu_we`=1) to `$0001` loads `cpu_wdata[2:0]` into the control register at the next rising clock edge. A write to any other address, `$0000` included, leaves the register unchanged.
- R3: A read (`cpu_we`=0) of `$0001` drives `port_rdata` = {5'b00000, control}. Every other access drives `port_rdata` = 8'h00.
- R4: With `lo_en`=0 and `hi_en`=0, all three switched windows select RAM, for any value of `io_sel`.
- R5: A read in `$A000-$BFFF` selects BASIC (sel bit 1) only when `lo_en`=1 and `hi_en`=1. Otherwise it selects RAM (sel bit 0).
- R6: A read in `$E000-$FFFF` selects KERNAL (sel bit 2) whenever `hi_en`=1. Otherwise it selects RAM.
- R7: With `lo_en` or `hi_en` set, `$D000-$DFFF` selects I/O (sel bit 4) for reads and writes when `io_sel`=1. When `io_sel`=0, a read selects character ROM (sel bit 3).
- R8: A write into any window currently mapped to a ROM (BASIC, KERNAL or character) selects RAM instead.
- R9: Every address outside the three windows, other than `$0000` and `$0001`, selects RAM.
- R10: At `$0000` and `$0001` no target select is active. At every other address exactly one select bit is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_we | input | 1 | 1 = write access, 0 = read access |
| cpu_wdata | input | 8 | CPU write data |
| tgt_sel | output | 5 | One-hot target: bit0 RAM, bit1 BASIC, bit2 KERNAL, bit3 character ROM, bit4 I/O |
| port_rdata | output | 8 | Read data of the control register at `$0001`, zero otherwise |
| ctrl_bits | output | 3 | Current control register value |

## Verification
For every one of the eight control values, the bench walks both ends of every 256-byte page, once as a read and once as a write. It compares the select against an arithmetic model. This sweep catches several kinds of error:

- A window edge that is off by one: the first or last byte of a page would pick the wrong target.
- Character ROM or I/O shown while both enable bits are clear: the `$D000` window would leave RAM at values 0 and 4.
- A write routed into a ROM: a ROM select would appear under `cpu_we`.

The port addresses are checked for a dead select, and the read data is checked for zero everywhere except `$0001`. Writes to `$0000` and into the I/O window must leave the register untouched. A decoder that compared fewer address bits would fail this check by loading new control bits.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int CTRL_W = 3;
    localparam int TGT_N  = 5;

    // control bit positions
    localparam int BIT_LO = 0;
    localparam int BIT_HI = 1;
    localparam int BIT_IO = 2;

    // one-hot target positions
    localparam int TGT_RAM   = 0;
    localparam int TGT_BASIC = 1;
    localparam int TGT_KERN  = 2;
    localparam int TGT_CHAR  = 3;
    localparam int TGT_IO    = 4;

    typedef enum logic [2:0] {
        WIN_PLAIN = 3'd0,
        WIN_LOW   = 3'd1,  // $A000-$BFFF
        WIN_MID   = 3'd2,  // $D000-$DFFF
        WIN_TOP   = 3'd3,  // $E000-$FFFF
        WIN_PORT  = 3'd4   // $0000 / $0001
    } window_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
    } ctrl_state_t;

endpackage

// File: rtl/pport_window_decode.sv
module pport_window_decode
    import pport_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DDR_ADDR  = 0,
    parameter int PORT_ADDR = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output window_e           win,
    output logic              port_hit
);

    localparam logic [ADDR_W-1:0] DDR_A  = ADDR_W'(DDR_ADDR);
    localparam logic [ADDR_W-1:0] PORT_A = ADDR_W'(PORT_ADDR);
    localparam logic [2:0] LOW_TAG = 3'b101;
    localparam logic [3:0] MID_TAG = 4'b1101;
    localparam logic [2:0] TOP_TAG = 3'b111;

    logic [2:0] top3;
    logic [3:0] top4;

    always_comb begin
        top3     = addr[ADDR_W-1 -: 3];
        top4     = addr[ADDR_W-1 -: 4];
        port_hit = (addr == PORT_A);
        if ((addr == DDR_A) || (addr == PORT_A)) begin
            win = WIN_PORT;
        end else if (top3 == LOW_TAG) begin
            win = WIN_LOW;
        end else if (top4 == MID_TAG) begin
            win = WIN_MID;
        end else if (top3 == TOP_TAG) begin
            win = WIN_TOP;
        end else begin
            win = WIN_PLAIN;
        end
    end

endmodule

// File: rtl/pport_target_sel.sv
module pport_target_sel
    import pport_pkg::*;
(
    input  window_e            win,
    input  logic [CTRL_W-1:0]  ctrl,
    input  logic               we,
    output logic [TGT_N-1:0]   sel
);

    logic lo, hi, io, any_rom;
    int unsigned tgt;
    logic        tgt_vld;

    always_comb begin
        lo      = ctrl[BIT_LO];
        hi      = ctrl[BIT_HI];
        io      = ctrl[BIT_IO];
        any_rom = lo | hi;
        tgt     = TGT_RAM;
        tgt_vld = 1'b1;
        unique case (win)
            WIN_PORT:  tgt_vld = 1'b0;
            WIN_LOW:   tgt = (lo && hi && !we) ? TGT_BASIC : TGT_RAM;
            WIN_MID: begin
                if (!any_rom)  tgt = TGT_RAM;
                else if (io)   tgt = TGT_IO;
                else           tgt = we ? TGT_RAM : TGT_CHAR;
            end
            WIN_TOP:   tgt = (hi && !we) ? TGT_KERN : TGT_RAM;
            default:   tgt = TGT_RAM;
        endcase
    end

    for (genvar i = 0; i < TGT_N; i++) begin : g_sel
        assign sel[i] = tgt_vld && (tgt == i);
    end

endmodule

// File: rtl/pport_ctrl_reg.sv
module pport_ctrl_reg
    import pport_pkg::*;
#(
    parameter logic [CTRL_W-1:0] RESET_VAL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_val,
    output logic [CTRL_W-1:0] ctrl
);

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctrl = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ctrl: RESET_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl = st_q.ctrl;

endmodule

// File: rtl/pport_bank_map.sv
module pport_bank_map
    import pport_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int DDR_ADDR  = 0,
    parameter int PORT_ADDR = 1,
    parameter logic [CTRL_W-1:0] RESET_VAL = 3'b111
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_we,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [TGT_N-1:0]   tgt_sel,
    output logic [DATA_W-1:0]  port_rdata,
    output logic [CTRL_W-1:0]  ctrl_bits
);

    localparam int PAD_W = DATA_W - CTRL_W;

    window_e win;
    logic    port_hit;
    logic    port_wr;
    logic    unused_wdata;

    pport_window_decode #(
        .ADDR_W   (ADDR_W),
        .DDR_ADDR (DDR_ADDR),
        .PORT_ADDR(PORT_ADDR)
    ) u_win (
        .addr    (cpu_addr),
        .win     (win),
        .port_hit(port_hit)
    );

    assign port_wr      = port_hit && cpu_we;
    assign unused_wdata = ^cpu_wdata[DATA_W-1:CTRL_W];

    pport_ctrl_reg #(
        .RESET_VAL(RESET_VAL)
    ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (port_wr),
        .wr_val(cpu_wdata[CTRL_W-1:0]),
        .ctrl  (ctrl_bits)
    );

    pport_target_sel u_sel (
        .win (win),
        .ctrl(ctrl_bits),
        .we  (cpu_we),
        .sel (tgt_sel)
    );

    always_comb begin
        port_rdata = '0;
        if (port_hit && !cpu_we) begin
            port_rdata = {{PAD_W{1'b0}}, ctrl_bits};
        end
    end

endmodule

// File: rtl/pport_bank_map_chk.sv
module pport_bank_map_chk
    import pport_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic              cpu_we,
    input logic [7:0]        cpu_wdata,
    input logic [TGT_N-1:0]  tgt_sel,
    input logic [7:0]        port_rdata,
    input logic [CTRL_W-1:0] ctrl_bits
);

    logic port_a;
    assign port_a = (cpu_addr == 16'h0001) || (cpu_addr == 16'h0000);

    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> ctrl_bits == 3'b111);

    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == 16'h0001) |=> ctrl_bits == $past(cpu_wdata[2:0]));

    a_r2_other_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && cpu_addr == 16'h0001) |=> $stable(ctrl_bits));

    a_r3_read_value: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_we && cpu_addr == 16'h0001) |-> port_rdata == {5'b00000, ctrl_bits});

    a_r4_all_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_bits[1:0] == 2'b00) |-> (tgt_sel[4:1] == 4'b0000));

    a_r8_no_rom_write: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we |-> !(tgt_sel[TGT_BASIC] || tgt_sel[TGT_KERN] || tgt_sel[TGT_CHAR]));

    a_r10_port_dead: assert property (@(posedge clk) disable iff (!rst_n)
        port_a |-> tgt_sel == '0);

    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        !port_a |-> $countones(tgt_sel) == 1);

endmodule

bind pport_bank_map pport_bank_map_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_we    (cpu_we),
    .cpu_wdata (cpu_wdata),
    .tgt_sel   (tgt_sel),
    .port_rdata(port_rdata),
    .ctrl_bits (ctrl_bits)
);

// File: tb/tb_pport_bank_map.sv
module tb_pport_bank_map;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0200;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [4:0]  tgt_sel;
    logic [7:0]  port_rdata;
    logic [2:0]  ctrl_bits;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    pport_bank_map dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_we    (cpu_we),
        .cpu_wdata (cpu_wdata),
        .tgt_sel   (tgt_sel),
        .port_rdata(port_rdata),
        .ctrl_bits (ctrl_bits)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s addr=%h we=%0b actual=%h expected=%h",
                     tag, cpu_addr, cpu_we, act, exp);
        end
    endtask

    // arithmetic model: returns one-hot select
    function automatic logic [4:0] model(logic [15:0] a, logic w, logic [2:0] c);
        logic lo, hi, io;
        lo = c[0]; hi = c[1]; io = c[2];
        if (a < 16'h0002) return 5'b00000;
        if (a >= 16'hA000 && a <= 16'hBFFF)
            return (lo && hi && !w) ? 5'b00010 : 5'b00001;
        if (a >= 16'hD000 && a <= 16'hDFFF) begin
            if (!(lo || hi)) return 5'b00001;
            if (io) return 5'b10000;
            return w ? 5'b00001 : 5'b01000;
        end
        if (a >= 16'hE000)
            return (hi && !w) ? 5'b00100 : 5'b00001;
        return 5'b00001;
    endfunction

    function automatic string tag_of(logic [15:0] a, logic w, logic [2:0] c);
        if (a < 16'h0002) return "R10";
        if (c[1:0] == 2'b00 && a >= 16'hA000 && !(a >= 16'hC000 && a < 16'hD000)) return "R4";
        if (w && (a >= 16'hA000) && !(a >= 16'hC000 && a < 16'hD000)) return "R8";
        if (a >= 16'hA000 && a <= 16'hBFFF) return "R5";
        if (a >= 16'hD000 && a <= 16'hDFFF) return "R7";
        if (a >= 16'hE000) return "R6";
        return "R9";
    endfunction

    task automatic access(logic [15:0] a, logic w, logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_we = w; cpu_wdata = d;
    endtask

    task automatic probe(logic [15:0] a, logic w, logic [2:0] c);
        access(a, w, {5'b00000, c});
        #1;
        check(tag_of(a, w, c), tgt_sel, model(a, w, c));
        check("R3", port_rdata, (a == 16'h0001 && !w) ? {5'b00000, c} : 8'h00);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", ctrl_bits, 3'b111);
        rst_n = 1'b1;
        access(16'h0001, 1'b0, 8'h00);
        #1;
        check("R1", port_rdata, 8'h07);
        check("R1", ctrl_bits, 3'b111);

        for (int c = 0; c < 8; c++) begin
            access(16'h0001, 1'b1, 8'hF8 | 8'(c));
            access(16'h0001, 1'b0, 8'h00);
            #1;
            check("R2", ctrl_bits, c);
            check("R3", port_rdata, c);
            probe(16'h0000, 1'b0, 3'(c));
            probe(16'h0001, 1'b0, 3'(c));
            probe(16'h0002, 1'b0, 3'(c));
            for (int p = 0; p < 256; p++) begin
                for (int w = 0; w < 2; w++) begin
                    probe(16'(p << 8), 1'(w), 3'(c));
                    probe(16'((p << 8) | 8'hFF), 1'(w), 3'(c));
                end
            end
        end

        // ignored writes: register must keep 3'b101
        access(16'h0001, 1'b1, 8'h05);
        access(16'h0000, 1'b1, 8'h02);
        access(16'hD001, 1'b1, 8'h00);
        access(16'h0101, 1'b1, 8'h03);
        access(16'h0001, 1'b0, 8'h00);
        #1;
        check("R2", port_rdata, 8'h05);

        // reset again returns to 3'b111
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", ctrl_bits, 3'b111);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule